// File: doc/BRIEF.md
# Serial EEPROM Target with Persistent Address Pointer

This block answers on a two-wire serial bus as a small byte-wide memory of up to 256 locations. It samples the clock and data lines on a fast system clock and only ever pulls the data line low. It holds its contents in an internal register array. A single address pointer selects the location for both stores and fetches. That pointer lives across bus transactions, so a controller can aim it with a short write and then fetch data later in a separate transaction.

A write transaction begins with the device address and a R/W bit of 0. The first byte after that loads the pointer, and every byte after it is stored where the pointer points, with the pointer stepping forward each time. A read transaction (R/W bit of 1) streams bytes out from the pointer and steps it after each byte, until the controller declines a byte. A write-protect input lets the controller clock data in and receive acknowledges while the contents stay unchanged.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, and whenever no transfer addresses this target, `sda_oe` is 0, which leaves SDA released.
- R2: The first byte after a START carries the 7-bit device address in bits 7..1 and R/W in bit 0 (1 = read). Only a match with `DEV_ADDR` gets an acknowledge (SDA low in the ninth clock). On a mismatch, SDA stays released until the next START, and storage and pointer stay unchanged.
- R3: In a write transfer, the first byte after the device address loads the pointer and is acknowledged. It is not stored.
- R4: Every later byte of a write transfer is acknowledged, stored at the pointer, and followed by a one-step increment of the pointer.
- R5: A read transfer shifts out the byte at the pointer MSB first. SDA changes only while SCL is low. The pointer increments once for each byte sent.
- R6: The pointer keeps its value across STOP and a new START. A write that carries only the address byte leaves the pointer at that address.
- R7: The pointer wraps from 0xFF to 0x00, for both stores and fetches.
- R8: While `wp_i` is 1, data bytes are acknowledged and the pointer still loads and increments, but storage is not modified.
- R9: When the controller does not acknowledge a read byte, the target releases SDA and sends no further data until the next START.
- R10: A START or STOP in the middle of a byte aborts it. A partial byte is neither stored nor loaded into the pointer, and a STOP releases SDA at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wp_i | input | 1 | Write protect; 1 blocks storage updates |

## Verification
The hardest condition to reach from the ports is a START that lands partway through a byte, after the device address has matched but before the pointer byte is complete. Only that case shows that a truncated byte neither loads nor advances the pointer. The stimulus reaches it by aiming the pointer, then sending the device address and four data bits, then issuing a repeated START followed by a read. The pointer wrap and write protection are reached by filling all 256 locations and by seeded random transfers that mix protected writes, address-only writes and reads of varying length against a bench model of memory and pointer.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_RX,
    ST_ACK_RX,
    ST_TX,
    ST_ACK_TX
  } ee_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edges while the clock is high on both samples
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ee_store.sv
module ee_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/i2c_ee_engine.sv
module i2c_ee_engine
  import i2c_ee_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         AW       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              wp_i,
  input  logic [BYTE_W-1:0] rdata,
  output logic              sda_oe,
  output logic              mem_we,
  output logic [BYTE_W-1:0] wdata,
  output logic [AW-1:0]     ptr_o,
  output ee_state_e         state_o
);
  ee_state_e         state_q, state_d;
  logic [2:0]        cnt_q, cnt_d;
  logic              flag_q, flag_d;   // byte complete (rx) or ack seen (tx)
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              pend_q, pend_d;   // pointer byte still expected
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              oe_q, oe_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    flag_d  = flag_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    pend_d  = pend_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    mem_we  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_DEV;
      cnt_d   = 3'd0;
      flag_d  = 1'b0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_RX: begin
          if (scl_rise) begin
            sh_d   = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d  = cnt_q + 3'd1;
            flag_d = (cnt_q == 3'd7);
          end else if (scl_fall && flag_q) begin
            flag_d = 1'b0;
            if (state_q == ST_DEV) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                state_d = ST_ACK_DEV;
                oe_d    = 1'b1;
                rw_d    = sh_q[0];
                pend_d  = ~sh_q[0];
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              state_d = ST_ACK_RX;
              oe_d    = 1'b1;
              if (pend_q) begin
                ptr_d  = sh_q[AW-1:0];
                pend_d = 1'b0;
              end else begin
                mem_we = ~wp_i;
                ptr_d  = ptr_q + 1'b1;
              end
            end
          end
        end
        ST_ACK_DEV, ST_ACK_RX: begin
          if (scl_fall) begin
            cnt_d  = 3'd0;
            flag_d = 1'b0;
            if (state_q == ST_ACK_DEV && rw_q) begin
              state_d = ST_TX;
              sh_d    = rdata;
              oe_d    = ~rdata[BYTE_W-1];
              ptr_d   = ptr_q + 1'b1;
            end else begin
              state_d = ST_RX;
              oe_d    = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              state_d = ST_ACK_TX;
              oe_d    = 1'b0;
              flag_d  = 1'b0;
            end else begin
              cnt_d = cnt_q + 3'd1;
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_ACK_TX: begin
          if (scl_rise) begin
            flag_d = ~sda_s;
          end else if (scl_fall) begin
            cnt_d = 3'd0;
            if (flag_q) begin
              state_d = ST_TX;
              sh_d    = rdata;
              oe_d    = ~rdata[BYTE_W-1];
              ptr_d   = ptr_q + 1'b1;
            end else begin
              state_d = ST_IDLE;
              oe_d    = 1'b0;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 3'd0;
      flag_q  <= 1'b0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      pend_q  <= 1'b0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      flag_q  <= flag_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      pend_q  <= pend_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wdata   = sh_q;
  assign ptr_o   = ptr_q;
  assign state_o = state_q;
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         DEPTH       = 256,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic wp_i
);
  localparam int AW = $clog2(DEPTH);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [BYTE_W-1:0] wdata, rdata;
  logic [AW-1:0]     ptr;
  ee_state_e         state;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ee_engine #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .wp_i(wp_i), .rdata(rdata), .sda_oe(sda_oe), .mem_we(mem_we),
    .wdata(wdata), .ptr_o(ptr), .state_o(state)
  );

  ee_store #(.DEPTH(DEPTH), .DW(BYTE_W)) u_store (
    .clk(clk), .we(mem_we), .addr(ptr), .wdata(wdata), .rdata(rdata)
  );
endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker
  import i2c_ee_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          stop_det,
  input logic          sda_oe,
  input logic          mem_we,
  input logic [AW-1:0] ptr,
  input ee_state_e     state
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  p_store_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr == AW'($past(ptr) + 1'b1)));

  p_drive_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && ptr == '1) |=> (ptr == '0));

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
endmodule

bind i2c_eeprom_slave i2c_ee_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe(sda_oe), .mem_we(mem_we), .ptr(ptr), .state(state)
);

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam logic [6:0] DEV  = 7'h50;
  localparam int         HALF = 6;
  localparam int         WD   = 190000;

  logic clk, rst_n, scl_m, sda_m, wp, sda_oe;
  logic sda_line;
  int   nchk, nerr;
  bit   done;
  logic [7:0] mem_m [256];
  logic [7:0] ptr_m;

  assign sda_line = sda_m & ~sda_oe;

  i2c_eeprom_slave #(.DEV_ADDR(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wp_i(wp)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b0; tick(HALF);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; tick(HALF);
      scl_m = 1'b1;   tick(HALF);
      scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF/2);
    acked = !sda_line;
    tick(HALF - HALF/2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(HALF);
      scl_m = 1'b1; tick(HALF/2);
      b = {b[6:0], sda_line};
      tick(HALF - HALF/2);
      scl_m = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    scl_m = 1'b0; tick(1);
    sda_m = 1'b1;
  endtask

  task automatic write_seq(input logic [7:0] a, input int n, input bit prot, input string req);
    bit ack;
    logic [7:0] d;
    wp = prot;
    i2c_start;
    send_byte({DEV, 1'b0}, ack); chk(ack, "R2 devaddr ack", ack, 1);
    send_byte(a, ack);           chk(ack, "R3 pointer byte ack", ack, 1);
    ptr_m = a;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, ack); chk(ack, req, ack, 1);
      if (!prot) mem_m[ptr_m] = d;
      ptr_m = ptr_m + 8'd1;
    end
    i2c_stop;
    wp = 1'b0;
  endtask

  task automatic read_seq(input int n, input string req);
    bit ack;
    logic [7:0] d;
    i2c_start;
    send_byte({DEV, 1'b1}, ack); chk(ack, "R2 read devaddr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n-1, d);
      chk(d == mem_m[ptr_m], req, d, mem_m[ptr_m]);
      ptr_m = ptr_m + 8'd1;
    end
    i2c_stop;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    void'($urandom(32'h1A2B3C4D));
    nchk = 0; nerr = 0; done = 1'b0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0;
    tick(5);
    chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0, "R1 idle release", sda_oe, 0);

    // R4 R7: fill all locations, pointer wraps back to 0x00
    write_seq(8'h00, 256, 1'b0, "R4 data ack");
    read_seq(3, "R7 R6 read after wrapping fill");

    // R6: address-only write, then separate read
    write_seq(8'h40, 0, 1'b0, "R6");
    read_seq(2, "R6 read continues from loaded pointer");

    // R7: read across the top
    write_seq(8'hFE, 0, 1'b0, "R7");
    read_seq(4, "R7 read wrap");

    // R8: protected write acks, advances pointer, stores nothing
    write_seq(8'h10, 3, 1'b1, "R8 protected ack");
    read_seq(1, "R8 pointer advanced under protect");
    write_seq(8'h10, 0, 1'b0, "R8");
    read_seq(3, "R8 contents unchanged");

    // R2: foreign address is ignored entirely
    write_seq(8'h22, 0, 1'b0, "R2");
    i2c_start;
    send_byte({DEV ^ 7'h01, 1'b0}, ack); chk(!ack, "R2 foreign address nack", ack, 0);
    send_byte(8'h00, ack);               chk(!ack, "R2 foreign byte nack", ack, 0);
    send_byte(8'hA5, ack);               chk(!ack, "R2 foreign data nack", ack, 0);
    i2c_stop;
    read_seq(1, "R2 pointer and storage untouched");

    // R9: controller declines, target stays silent
    i2c_start;
    send_byte({DEV, 1'b1}, ack); chk(ack, "R9 devaddr ack", ack, 1);
    recv_byte(1'b0, d);
    chk(d == mem_m[ptr_m], "R9 byte before nack", d, mem_m[ptr_m]);
    ptr_m = ptr_m + 8'd1;
    tick(4);
    chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R9 no data after nack", d, 8'hFF);
    i2c_stop;

    // R10: START in the middle of the pointer byte
    write_seq(8'h80, 0, 1'b0, "R10");
    i2c_start;
    send_byte({DEV, 1'b0}, ack); chk(ack, "R10 devaddr ack", ack, 1);
    send_bits(8'h0F, 4);
    i2c_start;
    send_byte({DEV, 1'b1}, ack); chk(ack, "R10 restart ack", ack, 1);
    recv_byte(1'b0, d);
    chk(d == mem_m[8'h80], "R10 partial byte discarded", d, mem_m[8'h80]);
    ptr_m = 8'h81;
    i2c_stop;
    chk(sda_oe == 1'b0, "R10 stop release", sda_oe, 0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      if ($urandom_range(1, 0) == 1)
        write_seq(8'($urandom), $urandom_range(4, 0), ($urandom_range(3, 0) == 0), "R4 R8 random write ack");
      else
        read_seq($urandom_range(4, 1), "R5 random read");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule